// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This unit owns a small word-wide synchronous memory and performs fetch-and-add, compare-and-swap and swap on it as locked sequences. A requester presents an opcode, a word address and up to two operand values on a valid/ready request channel. The unit reads the addressed word, works out the replacement, writes it back when the operation calls for a write, and returns the word that was there before on a valid/ready response channel. The address is used exactly as given: no offset and no pre- or post-indexing is applied.

A second, plain access port reads and writes the same memory. From the cycle after a request is accepted until the response handshake, `mem_busy` is high and that port has no effect. This is why nothing can land between the read and the write of an atomic operation. The port works again in the cycle after the response handshake.

Back-pressure rules: a request transfers on a rising edge where `req_valid` and `req_ready` are both high, and `req_ready` is high only when no operation is in flight. A response transfers on a rising edge where `rsp_valid` and `rsp_ready` are both high. While `rsp_ready` is low, `rsp_valid` stays high and `rsp_old` stays unchanged.

Top module: `atomic_rmw_unit`

## Requirements
- R1: Opcode 2'b00 (fetch-and-add) writes old + `req_opa` modulo 2^64 to the address and returns the old word. No overflow indication is produced.
- R2: Opcode 2'b01 (compare-and-swap) with a stored word equal to `req_opa` writes `req_opb` and returns the old word.
- R3: Opcode 2'b01 with a stored word different from `req_opa` leaves memory unchanged, returns the old word, and skips the write phase.
- R4: Opcode 2'b10 (swap) writes `req_opa` and returns the old word.
- R5: Opcode 2'b11 writes nothing and returns the stored word.
- R6: `req_ready` is high whenever the unit is idle. It is low from the cycle after acceptance until the cycle after the response handshake.
- R7: `rsp_valid` rises 3 clock edges after the accepting edge for operations that write, and 2 edges after it for operations that skip the write.
- R8: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_old` hold.
- R9: `mem_busy` is high from the cycle after acceptance through the response handshake cycle. Plain-port writes issued while it is high change no memory word.
- R10: When `mem_busy` is low, a plain write stores `mem_wdata`, and a plain read shows the word on `mem_rdata` one edge after the request.
- R11: An operation touches only the word at `req_addr`, unmodified; all other words keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit idle, request can be taken |
| req_op | input | 2 | 00 add, 01 compare-and-swap, 10 swap, 11 no write |
| req_addr | input | ADDR_W | Word address, used unmodified |
| req_opa | input | DATA_W | Addend, compare value, or swap value |
| req_opb | input | DATA_W | Replacement value for compare-and-swap |
| rsp_valid | output | 1 | Response offered |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_old | output | DATA_W | Word stored before the operation |
| mem_en | input | 1 | Plain-port access enable |
| mem_we | input | 1 | Plain-port write select |
| mem_addr | input | ADDR_W | Plain-port word address |
| mem_wdata | input | DATA_W | Plain-port write data |
| mem_rdata | output | DATA_W | Registered memory read data |
| mem_busy | output | 1 | Atomic operation in flight; plain port ignored |

## Verification
Each request is timed from its accepting edge. The bench samples on falling edges and counts the edges until `rsp_valid` appears. It expects two edges when the operation skips the write and three when it writes, and on every sample before that it checks that `req_ready` is low and `mem_busy` is high. Plain reads are sampled one falling edge after the enabling edge. Every result, whether returned or written back, is compared with a reference memory that the bench updates with its own functions. Some requests hold `rsp_ready` low for several cycles or try a plain write in the middle of the operation.

// File: rtl/atomic_rmw_pkg.sv
package atomic_rmw_pkg;
  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_CAS  = 2'b01,
    OP_SWAP = 2'b10,
    OP_NONE = 2'b11
  } rmw_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_CAPT,
    ST_WRITE,
    ST_RESP
  } rmw_state_e;
endpackage

// File: rtl/rmw_word_ram.sv
module rmw_word_ram #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) store[addr] <= wdata;
      else    rdata <= store[addr];
    end
  end
endmodule

// File: rtl/rmw_compute.sv
module rmw_compute
  import atomic_rmw_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  rmw_op_e           op,
  input  logic [DATA_W-1:0] old_word,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic [DATA_W-1:0] new_word,
  output logic              do_write
);
  always_comb begin
    new_word = old_word;
    do_write = 1'b0;
    unique case (op)
      OP_ADD: begin
        new_word = old_word + opa;
        do_write = 1'b1;
      end
      OP_CAS: begin
        new_word = opb;
        do_write = (old_word == opa);
      end
      OP_SWAP: begin
        new_word = opa;
        do_write = 1'b1;
      end
      default: begin
        new_word = old_word;
        do_write = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/rmw_sequencer.sv
module rmw_sequencer
  import atomic_rmw_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_opa,
  input  logic [DATA_W-1:0] req_opb,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_old,
  input  logic [DATA_W-1:0] rd_word,
  output logic              busy,
  output logic              at_re,
  output logic              at_we,
  output logic [ADDR_W-1:0] at_addr,
  output logic [DATA_W-1:0] at_wdata
);
  rmw_state_e        state;
  rmw_op_e           op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] opa_q, opb_q, old_q, new_q;
  logic [DATA_W-1:0] calc_word;
  logic              calc_wr;

  rmw_compute #(.DATA_W(DATA_W)) u_compute (
    .op       (op_q),
    .old_word (rd_word),
    .opa      (opa_q),
    .opb      (opb_q),
    .new_word (calc_word),
    .do_write (calc_wr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      op_q   <= OP_NONE;
      addr_q <= '0;
      opa_q  <= '0;
      opb_q  <= '0;
      old_q  <= '0;
      new_q  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (req_valid) begin
          op_q   <= rmw_op_e'(req_op);
          addr_q <= req_addr;
          opa_q  <= req_opa;
          opb_q  <= req_opb;
          state  <= ST_READ;
        end
        ST_READ: state <= ST_CAPT;
        ST_CAPT: begin
          old_q <= rd_word;
          new_q <= calc_word;
          state <= calc_wr ? ST_WRITE : ST_RESP;
        end
        ST_WRITE: state <= ST_RESP;
        ST_RESP: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign busy      = (state != ST_IDLE);
  assign rsp_valid = (state == ST_RESP);
  assign rsp_old   = old_q;
  assign at_re     = (state == ST_READ);
  assign at_we     = (state == ST_WRITE);
  assign at_addr   = addr_q;
  assign at_wdata  = new_q;

  assert_accept_locks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!req_ready && busy));

  assert_resp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_old)));

  assert_cas_miss_skip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CAPT && op_q == OP_CAS && rd_word != opa_q) |=> (state == ST_RESP));
endmodule

// File: rtl/rmw_port_mux.sv
module rmw_port_mux #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 4
) (
  input  logic              busy,
  input  logic              at_re,
  input  logic              at_we,
  input  logic [ADDR_W-1:0] at_addr,
  input  logic [DATA_W-1:0] at_wdata,
  input  logic              pl_en,
  input  logic              pl_we,
  input  logic [ADDR_W-1:0] pl_addr,
  input  logic [DATA_W-1:0] pl_wdata,
  output logic              ram_en,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata
);
  always_comb begin
    if (busy) begin
      ram_en    = at_re | at_we;
      ram_we    = at_we;
      ram_addr  = at_addr;
      ram_wdata = at_wdata;
    end else begin
      ram_en    = pl_en;
      ram_we    = pl_we;
      ram_addr  = pl_addr;
      ram_wdata = pl_wdata;
    end
  end
endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_opa,
  input  logic [DATA_W-1:0] req_opb,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_old,
  input  logic              mem_en,
  input  logic              mem_we,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W-1:0] mem_rdata,
  output logic              mem_busy
);
  logic              at_re, at_we;
  logic [ADDR_W-1:0] at_addr;
  logic [DATA_W-1:0] at_wdata;
  logic              ram_en, ram_we;
  logic [ADDR_W-1:0] ram_addr;
  logic [DATA_W-1:0] ram_wdata, ram_rdata;

  rmw_sequencer #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_op    (req_op),
    .req_addr  (req_addr),
    .req_opa   (req_opa),
    .req_opb   (req_opb),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_old   (rsp_old),
    .rd_word   (ram_rdata),
    .busy      (mem_busy),
    .at_re     (at_re),
    .at_we     (at_we),
    .at_addr   (at_addr),
    .at_wdata  (at_wdata)
  );

  rmw_port_mux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mux (
    .busy      (mem_busy),
    .at_re     (at_re),
    .at_we     (at_we),
    .at_addr   (at_addr),
    .at_wdata  (at_wdata),
    .pl_en     (mem_en),
    .pl_we     (mem_we),
    .pl_addr   (mem_addr),
    .pl_wdata  (mem_wdata),
    .ram_en    (ram_en),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata)
  );

  rmw_word_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk   (clk),
    .en    (ram_en),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (ram_wdata),
    .rdata (ram_rdata)
  );

  assign mem_rdata = ram_rdata;

  // Locked write: two cycles earlier the same word was read under the lock (R9, R11)
  assert_locked_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && mem_busy) |-> ($past(ram_en, 2) && !$past(ram_we, 2) &&
                              $past(ram_addr, 2) == ram_addr && $past(mem_busy)));

  assert_write_addr_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> ##2 ((ram_we && mem_busy) |-> ram_addr == $past(req_addr, 3)));
endmodule

// File: tb/atomic_rmw_unit_test.sv
module atomic_rmw_unit_test;
  localparam int DW = 64;
  localparam int AW = 4;
  localparam int NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_op = 2'b00;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_opa = '0, req_opb = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b0;
  logic [DW-1:0] rsp_old;
  logic          mem_en = 1'b0, mem_we = 1'b0;
  logic [AW-1:0] mem_addr = '0;
  logic [DW-1:0] mem_wdata = '0;
  logic [DW-1:0] mem_rdata;
  logic          mem_busy;

  int total = 0;
  int fails = 0;
  logic [DW-1:0] ref_mem [NW];

  always #10 clk = ~clk;

  atomic_rmw_unit #(.DATA_W(DW), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_opa(req_opa), .req_opb(req_opb),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_old(rsp_old),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_busy(mem_busy)
  );

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit ref_writes(input logic [1:0] op, input logic [DW-1:0] old,
                                    input logic [DW-1:0] a);
    case (op)
      2'b00, 2'b10: return 1'b1;
      2'b01:        return old == a;
      default:      return 1'b0;
    endcase
  endfunction

  function automatic logic [DW-1:0] ref_new(input logic [1:0] op, input logic [DW-1:0] old,
                                            input logic [DW-1:0] a, input logic [DW-1:0] b);
    case (op)
      2'b00:   return old + a;
      2'b01:   return (old == a) ? b : old;
      2'b10:   return a;
      default: return old;
    endcase
  endfunction

  function automatic logic [DW-1:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  task automatic plain_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    mem_en = 1'b1; mem_we = 1'b1; mem_addr = a; mem_wdata = d;
    @(negedge clk);
    mem_en = 1'b0; mem_we = 1'b0;
    ref_mem[a] = d;
  endtask

  task automatic plain_read_check(input logic [AW-1:0] a, input string tag);
    @(negedge clk);
    mem_en = 1'b1; mem_we = 1'b0; mem_addr = a;
    @(negedge clk);
    mem_en = 1'b0;
    chk(mem_rdata == ref_mem[a], tag, mem_rdata, ref_mem[a]);
  endtask

  task automatic do_rmw(input logic [1:0] op, input logic [AW-1:0] a,
                        input logic [DW-1:0] x, input logic [DW-1:0] y,
                        input int stall, input bit intrude, input string tag);
    logic [DW-1:0] old, nw;
    bit wr;
    int lat;
    bit hold_ok;
    old = ref_mem[a];
    wr  = ref_writes(op, old, x);
    nw  = ref_new(op, old, x, y);
    @(negedge clk);
    chk(req_ready == 1'b1, "R6 ready when idle", DW'(req_ready), 1);
    req_valid = 1'b1; req_op = op; req_addr = a; req_opa = x; req_opb = y;
    @(posedge clk);
    lat = 0;
    hold_ok = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
      if (i == 0 && intrude) begin
        mem_en = 1'b1; mem_we = 1'b1; mem_addr = a; mem_wdata = ~old;
      end else begin
        mem_en = 1'b0; mem_we = 1'b0;
      end
      if (rsp_valid) break;
      if (req_ready || !mem_busy) hold_ok = 1'b0;
      lat++;
    end
    mem_en = 1'b0; mem_we = 1'b0;
    chk(hold_ok, "R6/R9 ready low and busy high in flight", DW'(hold_ok), 1);
    chk(lat == (wr ? 3 : 2), "R7 response latency", DW'(lat), DW'(wr ? 3 : 2));
    chk(rsp_old == old, tag, rsp_old, old);
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_old == old && mem_busy, "R8 response held", rsp_old, old);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(req_ready && !mem_busy, "R6/R9 ready back after handshake",
        DW'({req_ready, mem_busy}), 2);
    ref_mem[a] = nw;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [1:0] op;
    logic [AW-1:0] a;
    logic [DW-1:0] x, y;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_busy, "reset state", DW'({req_ready, rsp_valid, mem_busy}), 4);

    for (int i = 0; i < NW; i++) plain_write(AW'(i), rnd64());
    for (int i = 0; i < NW; i++) plain_read_check(AW'(i), "R10 plain write/read");

    // directed corners
    plain_write(4'd3, 64'hFFFF_FFFF_FFFF_FFFF);
    do_rmw(2'b00, 4'd3, 64'd1, 64'd0, 0, 0, "R1 add wrap returns old");
    plain_read_check(4'd3, "R1 add wraps to zero");
    do_rmw(2'b01, 4'd5, ref_mem[5], 64'hCAFE_0000_1111_2222, 2, 0, "R2 cas hit returns old");
    plain_read_check(4'd5, "R2 cas hit stores new");
    do_rmw(2'b01, 4'd6, ~ref_mem[6], 64'h1234, 0, 0, "R3 cas miss returns old");
    plain_read_check(4'd6, "R3 cas miss leaves memory");
    do_rmw(2'b10, 4'd7, 64'hA5A5_5A5A_0F0F_F0F0, 64'd0, 3, 0, "R4 swap returns old");
    plain_read_check(4'd7, "R4 swap stores value");
    do_rmw(2'b11, 4'd8, 64'd99, 64'd77, 0, 0, "R5 no-write op returns old");
    plain_read_check(4'd8, "R5 no-write op leaves memory");
    do_rmw(2'b10, 4'd9, 64'h0BAD, 64'd0, 1, 1, "R9 swap with intruding write");
    plain_read_check(4'd9, "R9 plain write during busy ignored");
    plain_read_check(4'd10, "R11 neighbour untouched");

    for (int n = 0; n < 300; n++) begin
      op = 2'($urandom);
      a  = AW'($urandom);
      x  = ($urandom % 2 == 0) ? ref_mem[a] : rnd64();
      y  = rnd64();
      do_rmw(op, a, x, y, int'($urandom % 3), bit'($urandom % 8 == 0),
             "R1/R2/R3/R4/R5 random op returns old");
      if (n % 10 == 0) begin
        plain_read_check(a, "R11 random target word");
        plain_read_check(a + 4'd1, "R11 random neighbour word");
      end
    end
    for (int i = 0; i < NW; i++) plain_read_check(AW'(i), "R11 final memory sweep");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule